// File: doc/BRIEF.md
# Binary GCD Engine with Zero-Operand Flag

This block computes the greatest common divisor of two unsigned operands, 16 bits each by default. A one-cycle start pulse, given while the engine is not reducing, captures both operands. When the answer is ready, `done` rises and `result` holds the value. If either operand is zero, the engine does not compute. It raises `zero_err` together with `done` and drives `result` to zero.

The engine uses a binary (Stein) reduction. The capture cycle finds the power of two shared by both operands and saves its exponent. The same cycle strips every factor of two from each operand, using trailing-zero counters and right shifts. After that, each cycle replaces the pair with the smaller value and the odd part of the difference. When the two values match, that value is shifted left by the saved exponent and becomes the result.

The outputs hold until the next accepted start or reset. The block can therefore feed a slow host interface directly.

Top module: `gcd_engine`

## Requirements
- R1: While reset is held and after its release, `done`, `zero_err` and `result` all read 0.
- R2: A start sampled high on a rising edge while the engine is not reducing captures `opnd_a` and `opnd_b`. If both are non-zero, `done` and `zero_err` read 0 after that edge.
- R3: If either captured operand is zero, `done` and `zero_err` both read 1 after the capture edge, and `result` reads 0.
- R4: For two non-zero operands, `result` equals their greatest common divisor when `done` rises, and `zero_err` stays 0.
- R5: For equal non-zero operands, `done` rises on the second rising edge counted from the capture edge.
- R6: For any non-zero pair, `done` rises within 2·W+1 rising edges of the capture edge (33 for W=16).
- R7: A start pulse during a reduction is ignored. The running computation finishes with the result for the operands first captured.
- R8: Once set, `done`, `zero_err` and `result` hold their values until the next accepted start or reset, whatever the operand inputs do.
- R9: A power of two shared by both operands is restored in the result. For example, 48 and 64 give 16, and 0x8000 and 0x4000 give 0x4000.
- R10: A start given while `done` is high begins a new computation at once. The new result depends only on the new operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request to capture the operands |
| opnd_a | input | W (16) | First unsigned operand |
| opnd_b | input | W (16) | Second unsigned operand |
| done | output | 1 | Result (or error) is valid |
| zero_err | output | 1 | A captured operand was zero |
| result | output | W (16) | Greatest common divisor, or 0 on error |

## Verification
The bench builds the engine at its default width, W=16. At that width the extreme corners can be applied directly: the all-ones word against 1, the top bit against its neighbour, and consecutive Fibonacci numbers near the top of the range. These Fibonacci pairs drive the reduction toward its longest run and so test the 2·W+1 cycle bound. The seeded random pairs bias some operands toward zero and some toward shared powers of two. This covers the error path, the factor-of-two restore and back-to-back starts from the `done` state.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // Controller states. Idle and done both accept a new start.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REDUCE = 2'd1,
    ST_DONE   = 2'd2
  } gcd_state_e;

  // Number of tz units in the datapath: operand a, operand b, a|b, difference.
  localparam int TZ_UNITS = 4;

endpackage

// File: rtl/gcd_tz.sv
// Trailing-zero count. The value for an all-zero input is 0 and is never used.
module gcd_tz #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) cnt = CW'(i);
    end
  end

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_op,
  input  logic eq,
  output logic busy,
  output logic ld_op,
  output logic ld_zero,
  output logic step,
  output logic fin,
  output logic done,
  output logic zero_err
);

  gcd_state_e st_q, st_n;
  logic       done_q, done_n;
  logic       err_q, err_n;

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    done_n  = done_q;
    err_n   = err_q;
    ld_op   = 1'b0;
    ld_zero = 1'b0;
    step    = 1'b0;
    fin     = 1'b0;
    case (st_q)
      ST_REDUCE: begin
        if (eq) begin
          fin    = 1'b1;
          st_n   = ST_DONE;
          done_n = 1'b1;
        end else begin
          step = 1'b1;
        end
      end
      default: begin
        if (start) begin
          if (zero_op) begin
            ld_zero = 1'b1;
            st_n    = ST_DONE;
            done_n  = 1'b1;
            err_n   = 1'b1;
          end else begin
            ld_op  = 1'b1;
            st_n   = ST_REDUCE;
            done_n = 1'b0;
            err_n  = 1'b0;
          end
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign busy     = (st_q == ST_REDUCE);
  assign done     = done_q;
  assign zero_err = err_q;

  // Reduction-length counter, read only by the bound check below
  logic [BW-1:0] red_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    red_cnt_q <= '0;
    else if (busy) red_cnt_q <= red_cnt_q + 1'b1;
    else           red_cnt_q <= '0;
  end

  // R3
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |-> done);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(zero_err));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !eq |=> busy && !done);

  // R6
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    red_cnt_q <= BW'(2 * W));

  // R5
  eq_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eq |=> done && !zero_err && !busy);

endmodule

// File: rtl/gcd_dp.sv
module gcd_dp
  import gcd_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         ld_op,
  input  logic         ld_zero,
  input  logic         step,
  input  logic         fin,
  input  logic         busy,
  output logic         zero_op,
  output logic         eq,
  output logic [W-1:0] result
);

  logic [W-1:0]  a_q, b_q, a_n, b_n;
  logic [CW-1:0] k_q, k_n;
  logic [W-1:0]  res_q, res_n;
  logic          ab_en, res_en;

  logic [W-1:0]  lo, diff;
  logic          a_lt_b;

  logic [W-1:0]  tz_in  [TZ_UNITS];
  logic [CW-1:0] tz_cnt [TZ_UNITS];

  assign a_lt_b = (a_q < b_q);
  assign lo     = a_lt_b ? a_q : b_q;
  assign diff   = a_lt_b ? (b_q - a_q) : (a_q - b_q);
  assign eq     = (a_q == b_q);
  assign zero_op = (opnd_a == '0) || (opnd_b == '0);

  assign tz_in[0] = opnd_a;
  assign tz_in[1] = opnd_b;
  assign tz_in[2] = opnd_a | opnd_b;
  assign tz_in[3] = diff;

  for (genvar g = 0; g < TZ_UNITS; g++) begin : g_tz
    gcd_tz #(.W(W), .CW(CW)) u_tz (
      .vec (tz_in[g]),
      .cnt (tz_cnt[g])
    );
  end

  // Next-value logic
  always_comb begin
    a_n   = a_q;
    b_n   = b_q;
    k_n   = k_q;
    ab_en = ld_op | step;
    if (ld_op) begin
      a_n = opnd_a >> tz_cnt[0];
      b_n = opnd_b >> tz_cnt[1];
      k_n = tz_cnt[2];
    end else if (step) begin
      a_n = lo;
      b_n = diff >> tz_cnt[3];
    end
  end

  always_comb begin
    res_en = ld_zero | fin;
    res_n  = ld_zero ? '0 : (a_q << k_q);
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      k_q <= '0;
    end else if (ab_en) begin
      a_q <= a_n;
      b_q <= b_n;
      k_q <= k_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_n;
  end

  assign result = res_q;

  // R4
  odd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> a_q[0] && b_q[0]);

  // R3
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_zero |=> result == '0);

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         done,
  output logic         zero_err,
  output logic [W-1:0] result
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int BW = $clog2(2 * W + 2) + 1;

  logic busy, ld_op, ld_zero, step, fin, zero_op, eq;

  gcd_ctrl #(.W(W), .BW(BW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .zero_op  (zero_op),
    .eq       (eq),
    .busy     (busy),
    .ld_op    (ld_op),
    .ld_zero  (ld_zero),
    .step     (step),
    .fin      (fin),
    .done     (done),
    .zero_err (zero_err)
  );

  gcd_dp #(.W(W), .CW(CW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .ld_op   (ld_op),
    .ld_zero (ld_zero),
    .step    (step),
    .fin     (fin),
    .busy    (busy),
    .zero_op (zero_op),
    .eq      (eq),
    .result  (result)
  );

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(result));

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !zero_op |=> !done && !zero_err);

endmodule

// File: tb/gcd_engine_test.sv
`timescale 1ns/1ps
module gcd_engine_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] opnd_a, opnd_b;
  logic         done, zero_err;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gcd_engine #(.W(W)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .done     (done),
    .zero_err (zero_err),
    .result   (result)
  );

  function automatic logic [W-1:0] gcd_ref(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] p = x;
    logic [W-1:0] q = y;
    logic [W-1:0] t;
    while (q != 0) begin
      t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a start, then wait for done; lat counts edges after the capture edge.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
    int lat;
    logic d0, e0;
    logic [W-1:0] exp;
    @(negedge clk);
    start = 1'b1; opnd_a = a; opnd_b = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    d0 = done; e0 = zero_err;
    if (intrude && !done) begin
      // R7: new request during reduction must be ignored
      start = 1'b1; opnd_a = '0; opnd_b = 16'd5;
      @(negedge clk);
      start = 1'b0; lat++;
    end
    opnd_a = $urandom; opnd_b = $urandom;
    while (!done && lat < 2 * W + 3) begin
      @(negedge clk);
      lat++;
    end
    if (a == 0 || b == 0) begin
      chk(d0 && e0, "R3 done/err", {d0, e0}, 3);
      chk(result == 0, "R3 result", result, 0);
    end else begin
      exp = gcd_ref(a, b);
      if (!intrude) chk(!d0 && !e0, "R2 clear after start", {d0, e0}, 0);
      chk(result == exp, intrude ? "R7 result" : "R4 result", result, exp);
      chk(!zero_err, "R4 err", zero_err, 0);
      chk(lat <= 2 * W + 1, "R6 latency", lat, 2 * W + 1);
      if (a == b) chk(lat == 1, "R5 latency", lat, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] ra, rb;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    // R1: values under reset
    chk(!done && !zero_err && result == 0, "R1 in reset", {done, zero_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !zero_err && result == 0, "R1 after release", result, 0);

    // R9: shared powers of two
    run_op(16'd48, 16'd64, 1'b0);
    chk(result == 16, "R9 48,64", result, 16);
    run_op(16'h8000, 16'h4000, 1'b0);
    chk(result == 16'h4000, "R9 top bits", result, 16'h4000);

    // Corners
    run_op(16'hFFFF, 16'd1, 1'b0);
    run_op(16'hFFFF, 16'hFFFF, 1'b0);
    run_op(16'd46368, 16'd28657, 1'b0);
    run_op(16'd7, 16'd7, 1'b0);
    run_op(16'd0, 16'd0, 1'b0);
    run_op(16'd0, 16'd7, 1'b0);
    // R10: restart from done state after an error
    run_op(16'd7, 16'd0, 1'b0);
    run_op(16'd1071, 16'd462, 1'b0);
    chk(result == 21 && !zero_err, "R10 restart after error", result, 21);

    // R7: intruding start during reduction
    run_op(16'd1071, 16'd462, 1'b1);

    // R8: outputs hold while inputs wander
    held = result;
    for (int i = 0; i < 5; i++) begin
      opnd_a = $urandom; opnd_b = $urandom;
      @(negedge clk);
      chk(done && !zero_err && result == held, "R8 hold", result, held);
    end
    run_op(16'd9, 16'd0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      opnd_a = $urandom; opnd_b = $urandom;
      @(negedge clk);
      chk(done && zero_err && result == 0, "R8 hold err", {done, zero_err}, 3);
    end

    // Random pairs with bias toward zeros and shared powers of two
    for (int i = 0; i < 300; i++) begin
      ra = $urandom; rb = $urandom;
      if (($urandom % 16) == 0) ra = '0;
      if (($urandom % 16) == 1) rb = '0;
      if (($urandom % 4) == 0) begin
        ra = ra << ($urandom % 6);
        rb = rb << ($urandom % 6);
      end
      if (($urandom % 20) == 0) rb = ra;
      run_op(ra, rb, ($urandom % 10) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule